// File: doc/BRIEF.md
# Staggered Quadrature Bit Splitter

This block takes a serial bit stream, one bit per cycle in which a valid strobe is high, and deals the bits out in turn to an in-phase channel and a quadrature channel. Each channel holds its bit for two input bit times. The output is two signed levels, +1 for a one and -1 for a zero, that drive the product modulators of a quadrature transmitter. A strobe marks every clock edge on which either level is reloaded.

With the stagger input high, each channel is reloaded on the same edge that accepts its bit. The quadrature level therefore trails the in-phase level by one input bit time, which is half of a channel bit. Each channel changes in the middle of the other channel's bit, and a single step of the output phase never exceeds 90 degrees. With the stagger input low, the in-phase bit waits in a holding register. Both levels are then reloaded together on the edge that accepts the quadrature bit, which gives plain aligned quadrature keying with 180-degree steps, so the two schemes can be compared.

The level width is a parameter. The stagger input is expected to stay constant between resets.

Top module: `oqpsk_bit_splitter`

## Requirements
- R1: While reset is low and until each channel receives its first bit, both levels read -1 and the update strobe is low.
- R2: A level is a two's complement signed value LVL_W bits wide. Logic one maps to +1 (value 1) and logic zero maps to -1 (all bits set). No other value ever appears.
- R3: The first accepted bit after reset goes to the in-phase channel. After that, accepted bits alternate between the in-phase and quadrature channels.
- R4: In staggered mode, a channel's level takes its new bit on the clock edge that accepts that bit. It holds that bit until the edge that accepts that channel's next bit, so the quadrature level trails the in-phase level by one input bit.
- R5: In staggered mode, the two levels never change on the same clock edge.
- R6: In staggered mode, the update strobe is high for exactly one cycle after every edge that accepts a bit.
- R7: In aligned mode, an in-phase bit is held back. Both levels are reloaded together on the edge that accepts the following quadrature bit, and the strobe pulses once per pair.
- R8: In aligned mode, a dibit change such as 00 to 11 or 01 to 10 changes both levels on one edge.
- R9: A cycle with the valid strobe low leaves both levels unchanged, keeps the update strobe low, and keeps the in-phase/quadrature order.
- R10: LVL_W below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Serial bit present this cycle |
| bit_in | input | 1 | Serial data bit |
| stagger_en | input | 1 | 1: staggered channels, 0: aligned channels |
| i_lvl | output | LVL_W | In-phase level, signed, +1 or -1 |
| q_lvl | output | LVL_W | Quadrature level, signed, +1 or -1 |
| upd | output | 1 | Pulses after any edge that reloads a level |

## Verification
The bench sends every 8-bit word through the splitter in both modes. Idle cycles are placed between bit pairs for some words and left out for others. Sending every word shows that each bit reaches the correct channel with the correct sign, and it covers every dibit transition, including the diagonal ones. The idle gaps separate the order kept by the accepted-bit count from order kept by the clock count, and they show that the levels and strobe hold still when no bit is accepted. Running the same words in both modes shows the difference between a stagger, where only one level may change per edge, and aligned pairs, where both levels may flip at once.

// File: rtl/oqs_pkg.sv
package oqs_pkg;
   // channel slot that the next accepted bit is dealt to
   typedef enum logic {
      SLOT_I = 1'b0,
      SLOT_Q = 1'b1
   } oqs_slot_e;

   localparam int unsigned OQS_NCH = 2;   // in-phase, quadrature
   localparam int unsigned OQS_CH_I = 0;
   localparam int unsigned OQS_CH_Q = 1;
endpackage

// File: rtl/oqs_slot_seq.sv
module oqs_slot_seq
   import oqs_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_vld,
   input  logic                 bit_in,
   input  logic                 stagger_en,
   output logic [OQS_NCH-1:0]   ld,
   output logic [OQS_NCH-1:0]   ld_val,
   output logic                 upd
);
   oqs_slot_e slot_q;
   logic      pend_q;    // in-phase bit held back in aligned mode
   logic      upd_q;

   always_comb begin
      ld     = '0;
      ld_val = '0;
      if (bit_vld) begin
         if (slot_q == SLOT_I) begin
            if (stagger_en) begin
               ld[OQS_CH_I]     = 1'b1;
               ld_val[OQS_CH_I] = bit_in;
            end
         end else begin
            ld[OQS_CH_Q]     = 1'b1;
            ld_val[OQS_CH_Q] = bit_in;
            if (!stagger_en) begin
               ld[OQS_CH_I]     = 1'b1;
               ld_val[OQS_CH_I] = pend_q;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= SLOT_I;
         pend_q <= 1'b0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= |ld;
         if (bit_vld) begin
            slot_q <= (slot_q == SLOT_I) ? SLOT_Q : SLOT_I;
            if (slot_q == SLOT_I) pend_q <= bit_in;
         end
      end
   end

   assign upd = upd_q;
endmodule

// File: rtl/oqs_chan_hold.sv
module oqs_chan_hold #(
   parameter int unsigned LVL_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld,
   input  logic                     ld_val,
   output logic signed [LVL_W-1:0]  lvl
);
   localparam logic signed [LVL_W-1:0] LVL_POS = LVL_W'(1);
   localparam logic signed [LVL_W-1:0] LVL_NEG = {LVL_W{1'b1}};

   logic bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  bit_q <= 1'b0;
      else if (ld) bit_q <= ld_val;
   end

   assign lvl = bit_q ? LVL_POS : LVL_NEG;
endmodule

// File: rtl/oqpsk_bit_splitter.sv
module oqpsk_bit_splitter
   import oqs_pkg::*;
#(
   parameter int unsigned LVL_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bit_vld,
   input  logic                     bit_in,
   input  logic                     stagger_en,
   output logic signed [LVL_W-1:0]  i_lvl,
   output logic signed [LVL_W-1:0]  q_lvl,
   output logic                     upd
);
   // R10: a signed +1/-1 level needs at least two bits
   generate
      if (LVL_W < 2) begin : g_bad_width
         $error("oqpsk_bit_splitter: LVL_W must be at least 2");
      end
   endgenerate

   logic [OQS_NCH-1:0]              ld;
   logic [OQS_NCH-1:0]              ld_val;
   logic signed [LVL_W-1:0]         lvl_arr [OQS_NCH];

   oqs_slot_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_vld    (bit_vld),
      .bit_in     (bit_in),
      .stagger_en (stagger_en),
      .ld         (ld),
      .ld_val     (ld_val),
      .upd        (upd)
   );

   generate
      for (genvar c = 0; c < OQS_NCH; c++) begin : g_chan
         oqs_chan_hold #(.LVL_W(LVL_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld[c]),
            .ld_val (ld_val[c]),
            .lvl    (lvl_arr[c])
         );
      end
   endgenerate

   assign i_lvl = lvl_arr[OQS_CH_I];
   assign q_lvl = lvl_arr[OQS_CH_Q];
endmodule

// File: rtl/oqpsk_bit_splitter_chk.sv
module oqpsk_bit_splitter_chk #(
   parameter int unsigned LVL_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bit_vld,
   input  logic                     stagger_en,
   input  logic signed [LVL_W-1:0]  i_lvl,
   input  logic signed [LVL_W-1:0]  q_lvl,
   input  logic                     upd
);
   localparam logic signed [LVL_W-1:0] CK_POS = LVL_W'(1);
   localparam logic signed [LVL_W-1:0] CK_NEG = {LVL_W{1'b1}};

   a_r2_i_level: assert property (@(posedge clk) disable iff (!rst_n)
      (i_lvl == CK_POS) || (i_lvl == CK_NEG));

   a_r2_q_level: assert property (@(posedge clk) disable iff (!rst_n)
      (q_lvl == CK_POS) || (q_lvl == CK_NEG));

   a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stagger_en) |-> ($stable(i_lvl) || $stable(q_lvl)));

   a_r6_upd_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> $past(bit_vld));

   a_r4_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(i_lvl) || !$stable(q_lvl)) |-> upd);

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_vld) |-> ($stable(i_lvl) && $stable(q_lvl) && !upd));
endmodule

bind oqpsk_bit_splitter oqpsk_bit_splitter_chk #(.LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_vld    (bit_vld),
   .stagger_en (stagger_en),
   .i_lvl      (i_lvl),
   .q_lvl      (q_lvl),
   .upd        (upd)
);

// File: tb/oqpsk_bit_splitter_tb_top.sv
module oqpsk_bit_splitter_tb_top;
   localparam int unsigned LW = 2;
   localparam logic signed [LW-1:0] POS = LW'(1);
   localparam logic signed [LW-1:0] NEG = {LW{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic stagger_en = 1'b1;
   logic signed [LW-1:0] i_lvl, q_lvl;
   logic upd;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic m_slot, m_pend, m_i, m_q, m_upd;

   always #10 clk = ~clk;   // 50 MHz

   oqpsk_bit_splitter #(.LVL_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .stagger_en(stagger_en), .i_lvl(i_lvl), .q_lvl(q_lvl), .upd(upd)
   );

   function automatic logic signed [LW-1:0] lv(input logic b);
      return b ? POS : NEG;
   endfunction

   task automatic check(input string tag, input logic ok, input string got, input string exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%s expected=%s", tag, got, exp);
      end
   endtask

   task automatic check_outs(input string tag);
      check(tag, (i_lvl == lv(m_i)) && (q_lvl == lv(m_q)) && (upd == m_upd),
            $sformatf("i=%0d q=%0d upd=%0b", i_lvl, q_lvl, upd),
            $sformatf("i=%0d q=%0d upd=%0b", lv(m_i), lv(m_q), m_upd));
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0; bit_vld = 1'b0; stagger_en = mode;
      m_slot = 0; m_pend = 0; m_i = 0; m_q = 0; m_upd = 0;
      repeat (2) @(negedge clk);
      check_outs("R1 reset state");
      rst_n = 1'b1;
   endtask

   // one cycle: inputs driven at negedge, outputs checked at next negedge
   task automatic step(input logic v, input logic b, input string tag);
      logic pi, pq;
      pi = m_i; pq = m_q;
      bit_vld = v; bit_in = b;
      @(posedge clk);
      m_upd = 0;
      if (v) begin
         if (!m_slot) begin
            if (stagger_en) begin m_i = b; m_upd = 1; end
            else m_pend = b;
         end else begin
            m_q = b; m_upd = 1;
            if (!stagger_en) m_i = m_pend;
         end
         m_slot = ~m_slot;
      end
      @(negedge clk);
      bit_vld = 1'b0;
      check_outs(tag);
      if (stagger_en) begin
         // R5: never both levels move on one edge
         check("R5 single-level change",
               !((i_lvl != lv(pi)) && (q_lvl != lv(pq))),
               $sformatf("i %0d->%0d q %0d->%0d", lv(pi), i_lvl, lv(pq), q_lvl),
               "at most one level changes");
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      // directed: first bit to I, R3/R4 in staggered mode
      do_reset(1'b1);
      step(1'b0, 1'b1, "R9 idle after reset");
      step(1'b1, 1'b1, "R3 first bit lands on I");
      step(1'b0, 1'b0, "R9 idle keeps order");
      step(1'b1, 1'b1, "R4 Q takes second bit");
      step(1'b1, 1'b0, "R4 I reloads, Q holds");
      check("R2 level encodings", (i_lvl == NEG) && (q_lvl == POS),
            $sformatf("i=%0d q=%0d", i_lvl, q_lvl), "i=-1 q=1");

      // directed: aligned 00 -> 11 flips both on one edge (R7, R8)
      do_reset(1'b0);
      step(1'b1, 1'b0, "R7 I bit held back");
      step(1'b1, 1'b0, "R7 pair 00 loads both");
      step(1'b1, 1'b1, "R7 I held, no update");
      check("R7 I not yet visible", i_lvl == NEG,
            $sformatf("%0d", i_lvl), "-1");
      step(1'b1, 1'b1, "R8 pair 11 flips both");
      check("R8 both changed", (i_lvl == POS) && (q_lvl == POS),
            $sformatf("i=%0d q=%0d", i_lvl, q_lvl), "i=1 q=1");
      step(1'b1, 1'b0, "R7 next I held");
      step(1'b1, 1'b1, "R8 pair 01 from 11");

      // exhaustive sweep of 8-bit words in both modes, with and without gaps
      for (int mode = 0; mode < 2; mode++) begin
         do_reset(mode[0]);
         for (int w = 0; w < 256; w++) begin
            for (int k = 0; k < 8; k++) begin
               step(1'b1, w[k], mode[0] ? "R4 R6 staggered sweep" : "R7 aligned sweep");
               if (w[0] && k[0]) step(1'b0, 1'b0, "R9 idle gap in sweep");
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule